// File: doc/BRIEF.md
# Busy-Interrupt Serial ADC Read Controller

This block sits on the host side of a 16-bit successive-approximation converter that is wired with four signals: a convert-start line, an active-low read-select line, a serial clock and a serial data return. At a fixed sample rate it raises the convert-start line while read-select is high, which puts the converter into its chip-select mode. It keeps convert-start high until the read has finished. The start line never changes while a read is in progress, so the sampling instant does not depend on when the data is read.

In busy mode the controller pulls read-select low early in the conversion. This arms the converter's start bit. The controller then waits for the data line, which idles high through a pull-up, to fall. That falling edge marks the end of the conversion. The controller then runs 17 serial clock cycles. It discards the start bit and shifts in the 16 data bits, most significant bit first. In fixed-timeout mode no start bit is used. The controller waits out the worst-case conversion time, selects the converter and runs 16 clock cycles. In both modes the result appears with a one-cycle strobe once read-select has returned high. In busy mode a watchdog abandons the frame if the data line never falls.

Top module: `adc_busy_reader`

## Requirements
- R1: While reset is asserted and right after it, conv_start is 0, rd_sel_n is 1, ser_clk is 0, and sample_valid and wait_timeout are 0.
- R2: While enable is 1, a frame starts every FRAME_CYC clock cycles. At each start, conv_start rises while rd_sel_n is 1. While enable is 0, no frame starts.
- R3: Once conv_start rises, it stays 1 for as long as rd_sel_n is 0. It returns to 0 in the same cycle that rd_sel_n returns to 1 at the end of the frame.
- R4: busy_mode is sampled when conv_start rises. In busy mode (1), rd_sel_n falls exactly ARM_CYC cycles after conv_start rises. The read then begins only after ser_din falls from 1 to 0.
- R5: In busy mode, a read has exactly DATA_W+1 ser_clk cycles. The bit captured at the first falling edge is the start bit (0) and is dropped. The next DATA_W falling edges capture the data, most significant bit first.
- R6: In fixed-timeout mode (busy_mode 0), rd_sel_n falls exactly CONV_MAX_CYC cycles after conv_start rises. The read then has exactly DATA_W ser_clk cycles, and the first falling edge captures the most significant bit.
- R7: ser_clk is 0 whenever rd_sel_n is 1. During a read, each high phase lasts SCK_HALF clock cycles.
- R8: sample_valid is a single-cycle pulse. It comes exactly one cycle after rd_sel_n returns to 1 at the end of a read, and sample_data then holds the captured word.
- R9: In busy mode, if ser_din has not fallen CONV_MAX_CYC cycles after conv_start rose, wait_timeout pulses for one cycle. In that same cycle rd_sel_n returns to 1 and conv_start to 0. No ser_clk cycle and no sample_valid follow for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Lets the frame timer start conversions |
| busy_mode | input | 1 | 1: wait for the start bit; 0: fixed worst-case wait |
| ser_din | input | 1 | Serial data from the converter (pulled up when idle) |
| conv_start | output | 1 | Convert-start line to the converter |
| rd_sel_n | output | 1 | Active-low read select, also arms the start bit |
| ser_clk | output | 1 | Serial read clock |
| sample_data | output | DATA_W | Last captured result |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| wait_timeout | output | 1 | One-cycle strobe when the start bit never arrives |

## Verification
The bench builds the block with DATA_W 16, FRAME_CYC 150, SCK_HALF 2, ARM_CYC 3 and CONV_MAX_CYC 40. A behavioural converter model in the bench finishes each conversion in 25 cycles. The arming point therefore falls well inside the conversion, and both the busy-mode and the fixed-wait reads finish inside one frame, so the frame period can be measured between back-to-back starts. A half-period of two cycles leaves the model a settled cycle between its data change and the capturing edge. A watchdog of 40 cycles is short enough to test the abandoned-frame path with a model that withholds the start bit.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_CONV,
    RD_ARMED,
    RD_SHIFT,
    RD_CLOSE
  } rd_state_e;

  // Number of serial clock cycles in one read: a start bit adds one.
  function automatic int unsigned edges_per_read(input logic busy, input int unsigned data_w);
    return busy ? data_w + 1 : data_w;
  endfunction

  // Zero-based index of the first falling edge whose bit is kept.
  function automatic int unsigned first_data_edge(input logic busy);
    return busy ? 1 : 0;
  endfunction

  // Cycle count (from the start edge) at which read select is lowered.
  function automatic int unsigned select_point(input logic busy, input int unsigned arm_cyc,
                                               input int unsigned max_cyc);
    return busy ? arm_cyc - 1 : max_cyc - 1;
  endfunction

endpackage

// File: rtl/adc_rd_rate.sv
module adc_rd_rate #(
  parameter int unsigned FRAME_CYC = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int unsigned CW = (FRAME_CYC > 2) ? $clog2(FRAME_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = enable && (cnt == LAST);

endmodule

// File: rtl/adc_rd_fall_det.sv
module adc_rd_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  assign fall = s2 & ~s1;

endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IDX_W-1:0] total,
  output logic             sck,
  output logic             fall_now,
  output logic [IDX_W-1:0] fall_idx,
  output logic             last_now
);
  localparam int unsigned DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DW-1:0] HALF_END = DW'(SCK_HALF - 1);

  logic [DW-1:0]    div;
  logic [IDX_W-1:0] idx;
  logic             half_done;

  assign half_done = (div == HALF_END);
  assign fall_now  = run && sck && half_done;
  assign fall_idx  = idx;
  assign last_now  = fall_now && (idx == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b0;
      div <= '0;
      idx <= '0;
    end else if (!run) begin
      sck <= 1'b0;
      div <= '0;
      idx <= '0;
    end else if (half_done) begin
      div <= '0;
      sck <= ~sck;
      if (sck) idx <= idx + 1'b1;
    end else begin
      div <= div + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  skip,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (strobe && (idx >= skip)) begin
      word <= {word[DATA_W-2:0], din};
    end
  end

endmodule

// File: rtl/adc_busy_reader.sv
module adc_busy_reader #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned FRAME_CYC    = 150,
  parameter int unsigned SCK_HALF     = 2,
  parameter int unsigned ARM_CYC      = 3,
  parameter int unsigned CONV_MAX_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              busy_mode,
  input  logic              ser_din,
  output logic              conv_start,
  output logic              rd_sel_n,
  output logic              ser_clk,
  output logic [DATA_W-1:0] sample_data,
  output logic              sample_valid,
  output logic              wait_timeout
);
  import adc_rd_pkg::*;

  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam int unsigned TW    = $clog2(CONV_MAX_CYC + 1);
  localparam logic [TW-1:0] WATCH_END = TW'(CONV_MAX_CYC - 1);

  rd_state_e         st;
  logic [TW-1:0]     cnt;
  logic              mode_busy_q;

  // Named internal events
  logic              tick;
  logic              din_fall;
  logic              sck_fall_evt;
  logic              read_last;
  logic [IDX_W-1:0]  fall_idx;
  logic [IDX_W-1:0]  edge_total;
  logic [IDX_W-1:0]  edge_skip;
  logic [TW-1:0]     sel_low_at;
  logic [DATA_W-1:0] cap_word;
  logic              shift_run;

  assign edge_total = IDX_W'(edges_per_read(mode_busy_q, DATA_W));
  assign edge_skip  = IDX_W'(first_data_edge(mode_busy_q));
  assign sel_low_at = TW'(select_point(mode_busy_q, ARM_CYC, CONV_MAX_CYC));
  assign shift_run  = (st == RD_SHIFT);

  adc_rd_rate #(.FRAME_CYC(FRAME_CYC)) i_rate (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick)
  );

  adc_rd_fall_det i_fall (
    .clk(clk), .rst_n(rst_n), .din(ser_din), .fall(din_fall)
  );

  adc_rd_sclk #(.SCK_HALF(SCK_HALF), .IDX_W(IDX_W)) i_sclk (
    .clk(clk), .rst_n(rst_n), .run(shift_run), .total(edge_total),
    .sck(ser_clk), .fall_now(sck_fall_evt), .fall_idx(fall_idx), .last_now(read_last)
  );

  adc_rd_capture #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_cap (
    .clk(clk), .rst_n(rst_n), .strobe(sck_fall_evt), .idx(fall_idx),
    .skip(edge_skip), .din(ser_din), .word(cap_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= RD_IDLE;
      cnt          <= '0;
      mode_busy_q  <= 1'b0;
      conv_start   <= 1'b0;
      rd_sel_n     <= 1'b1;
      sample_data  <= '0;
      sample_valid <= 1'b0;
      wait_timeout <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      wait_timeout <= 1'b0;
      case (st)
        RD_IDLE: begin
          if (tick) begin
            conv_start  <= 1'b1;
            rd_sel_n    <= 1'b1;
            cnt         <= '0;
            mode_busy_q <= busy_mode;
            st          <= RD_CONV;
          end
        end
        RD_CONV: begin
          cnt <= cnt + 1'b1;
          if (cnt == sel_low_at) begin
            rd_sel_n <= 1'b0;
            st       <= mode_busy_q ? RD_ARMED : RD_SHIFT;
          end
        end
        RD_ARMED: begin
          cnt <= cnt + 1'b1;
          if (din_fall) begin
            st <= RD_SHIFT;
          end else if (cnt == WATCH_END) begin
            wait_timeout <= 1'b1;
            rd_sel_n     <= 1'b1;
            conv_start   <= 1'b0;
            st           <= RD_IDLE;
          end
        end
        RD_SHIFT: begin
          if (read_last) begin
            rd_sel_n   <= 1'b1;
            conv_start <= 1'b0;
            st         <= RD_CLOSE;
          end
        end
        RD_CLOSE: begin
          sample_valid <= 1'b1;
          sample_data  <= cap_word;
          st           <= RD_IDLE;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_busy_reader_chk.sv
module adc_busy_reader_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic rd_sel_n,
  input logic ser_clk,
  input logic sample_valid,
  input logic wait_timeout,
  input logic mode_busy_q,
  input logic sck_fall_evt
);
  logic [IDX_W-1:0] fall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            fall_cnt <= '0;
    else if (rd_sel_n)     fall_cnt <= '0;
    else if (sck_fall_evt) fall_cnt <= fall_cnt + 1'b1;
  end

  assert_select_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> rd_sel_n);

  assert_start_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_n |-> conv_start);

  assert_edge_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_sel_n) |-> (fall_cnt == '0) ||
      (fall_cnt == IDX_W'(mode_busy_q ? DATA_W + 1 : DATA_W)));

  assert_clock_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !rd_sel_n);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_valid_after_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> rd_sel_n && $past(rd_sel_n) && !$past(rd_sel_n, 2));

  assert_abort_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_timeout |-> rd_sel_n && !conv_start && !sample_valid);

endmodule

bind adc_busy_reader adc_busy_reader_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .rd_sel_n(rd_sel_n),
  .ser_clk(ser_clk), .sample_valid(sample_valid), .wait_timeout(wait_timeout),
  .mode_busy_q(mode_busy_q), .sck_fall_evt(sck_fall_evt)
);

// File: tb/test_adc_busy_reader.sv
module test_adc_busy_reader;
  localparam int DATA_W = 16, FRAME_CYC = 150, SCK_HALF = 2, ARM_CYC = 3, CONV_MAX_CYC = 40;
  localparam int CONV_LEN = 25;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, busy_mode = 1'b0, ser_din = 1'b1;
  logic conv_start, rd_sel_n, ser_clk, sample_valid, wait_timeout;
  logic [DATA_W-1:0] sample_data;

  always #10 clk = ~clk;

  adc_busy_reader #(.DATA_W(DATA_W), .FRAME_CYC(FRAME_CYC), .SCK_HALF(SCK_HALF),
                    .ARM_CYC(ARM_CYC), .CONV_MAX_CYC(CONV_MAX_CYC)) i_adc_busy_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .busy_mode(busy_mode), .ser_din(ser_din),
    .conv_start(conv_start), .rd_sel_n(rd_sel_n), .ser_clk(ser_clk),
    .sample_data(sample_data), .sample_valid(sample_valid), .wait_timeout(wait_timeout));

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural converter model
  logic [15:0] adc_word = 16'h0000;
  logic mute = 1'b0;
  logic m_conv = 1'b0, m_out = 1'b0, p_cnv = 1'b0, p_sel = 1'b1, p_sck = 1'b0;
  int m_left = 0;
  logic [15:0] m_sh = '0;

  always @(posedge clk) begin
    p_cnv <= conv_start; p_sel <= rd_sel_n; p_sck <= ser_clk;
    if (!rst_n) begin
      m_conv <= 1'b0; m_out <= 1'b0; ser_din <= 1'b1;
    end else if (conv_start && !p_cnv && rd_sel_n) begin
      m_conv <= 1'b1; m_left <= CONV_LEN; m_sh <= adc_word; m_out <= 1'b0; ser_din <= 1'b1;
    end else if (m_conv) begin
      m_left <= m_left - 1;
      if (m_left == 1) begin
        m_conv <= 1'b0;
        if (!rd_sel_n && !mute) begin m_out <= 1'b1; ser_din <= 1'b0; end
      end
    end else if (m_out) begin
      if (rd_sel_n || !conv_start) begin
        m_out <= 1'b0; ser_din <= 1'b1;
      end else if (p_sck && !ser_clk) begin
        ser_din <= m_sh[15]; m_sh <= {m_sh[14:0], 1'b0};
      end
    end else if (!rd_sel_n && p_sel && conv_start) begin
      m_out <= 1'b1; ser_din <= m_sh[15]; m_sh <= {m_sh[14:0], 1'b0};
    end
  end

  // Monitor sampled on the falling clock edge
  int ncyc = 0, n_cnv = 0, t_cnv = 0, t_cnv_prev = 0, t_sel_fall = 0, t_sel_rise = 0;
  int n_sck = 0, t_sck_rise = 0, w_sck = 0, n_valid = 0, t_valid = 0, n_to = 0, t_to = 0;
  int n_hold_bad = 0, n_gate_bad = 0;
  logic [DATA_W-1:0] v_data = '0;
  logic q_cnv = 1'b0, q_sel = 1'b1, q_sck = 1'b0;

  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (conv_start && !q_cnv) begin n_cnv++; t_cnv_prev = t_cnv; t_cnv = ncyc; end
      if (!rd_sel_n && q_sel) begin t_sel_fall = ncyc; n_sck = 0; end
      if (rd_sel_n && !q_sel) t_sel_rise = ncyc;
      if (ser_clk && !q_sck) begin n_sck++; t_sck_rise = ncyc; end
      if (!ser_clk && q_sck) w_sck = ncyc - t_sck_rise;
      if (sample_valid) begin n_valid++; t_valid = ncyc; v_data = sample_data; end
      if (wait_timeout) begin n_to++; t_to = ncyc; end
      if (!rd_sel_n && !conv_start) n_hold_bad++;
      if (ser_clk && rd_sel_n) n_gate_bad++;
    end
    q_cnv = conv_start; q_sel = rd_sel_n; q_sck = ser_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_cnv = 0; n_valid = 0; n_to = 0; n_sck = 0; n_hold_bad = 0; n_gate_bad = 0; w_sck = 0;
  endtask

  task automatic run_frame();
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (n_valid > 0 || n_to > 0) break;
    end
    enable = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 conv_start in reset", int'(conv_start), 0);
    chk("R1 rd_sel_n in reset", int'(rd_sel_n), 1);
    chk("R1 ser_clk in reset", int'(ser_clk), 0);
    chk("R1 sample_valid in reset", int'(sample_valid), 0);
    chk("R1 wait_timeout in reset", int'(wait_timeout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_sel_n after reset", int'(rd_sel_n), 1);
  endtask

  task automatic test_busy_read(input logic [15:0] w);
    clear_mon(); mute = 1'b0; busy_mode = 1'b1; adc_word = w;
    run_frame();
    chk("R4 select delay after start", t_sel_fall - t_cnv, ARM_CYC);
    chk("R5 clock cycles busy read", n_sck, DATA_W + 1);
    chk("R5 data busy read", int'(v_data), int'(w));
    chk("R8 valid count", n_valid, 1);
    chk("R8 valid one cycle after select release", t_valid - t_sel_rise, 1);
    chk("R3 start held while selected", n_hold_bad, 0);
    chk("R3 start low after frame", int'(conv_start), 0);
    chk("R7 clock gated by select", n_gate_bad, 0);
    chk("R7 clock high width", w_sck, SCK_HALF);
    chk("R9 no timeout on good read", n_to, 0);
  endtask

  task automatic test_plain_read(input logic [15:0] w);
    clear_mon(); mute = 1'b0; busy_mode = 1'b0; adc_word = w;
    run_frame();
    chk("R6 select delay fixed wait", t_sel_fall - t_cnv, CONV_MAX_CYC);
    chk("R6 clock cycles fixed wait", n_sck, DATA_W);
    chk("R6 data fixed wait", int'(v_data), int'(w));
    chk("R8 valid one cycle after select release", t_valid - t_sel_rise, 1);
    chk("R3 start held while selected", n_hold_bad, 0);
  endtask

  task automatic test_timeout();
    clear_mon(); mute = 1'b1; busy_mode = 1'b1; adc_word = 16'h1234;
    run_frame();
    chk("R9 timeout count", n_to, 1);
    chk("R9 timeout delay", t_to - t_cnv, CONV_MAX_CYC);
    chk("R9 no valid on timeout", n_valid, 0);
    chk("R9 no clock on timeout", n_sck, 0);
    chk("R9 select released", int'(rd_sel_n), 1);
    chk("R9 start released", int'(conv_start), 0);
    mute = 1'b0;
  endtask

  task automatic test_period();
    clear_mon(); mute = 1'b0; busy_mode = 1'b1; adc_word = 16'h0F0F;
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (n_cnv >= 2) break;
    end
    enable = 1'b0;
    chk("R2 frame period", t_cnv - t_cnv_prev, FRAME_CYC);
    chk("R2 starts seen", n_cnv, 2);
    repeat (200) @(negedge clk);
  endtask

  task automatic test_disabled();
    clear_mon();
    enable = 1'b0;
    repeat (500) @(negedge clk);
    chk("R2 no start while disabled", n_cnv, 0);
    chk("R2 no valid while disabled", n_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_busy_read(16'hA5C3);
    test_busy_read(16'hFFFF);
    test_busy_read(16'h0000);
    test_plain_read(16'h8001);
    test_plain_read(16'h7FFE);
    test_timeout();
    test_busy_read(16'h3C96);
    test_period();
    test_disabled();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule